// File: doc/BRIEF.md
# Serial-Bus Identification Memory

This block is a 256-byte memory that answers as a target on a two-wire serial bus (I2C). It is used to identify a memory module to a host. Its clock line is an input only. Its data line is open-drain: the block never drives it high and only asserts a pull-low enable. Three strap inputs set the low three bits of its 7-bit bus address, so eight of these devices can share one bus.

Both bus lines are brought into the core clock domain through synchronisers. Start, stop and clock-edge events are derived from the synchronised lines, and a single state machine steps through the transfer. The supported transfers are:
- a byte write, which sends a word address followed by data;
- a random read, which sends a word address, then a repeated start and a read address;
- a sequential read;
- a current-address read.

The lower half of the array holds identification data that cannot be written. Each byte there reads as its address XOR `ROM_SEED`. The upper half holds user data, which resets to 8'hFF.

When a stop ends a transfer that wrote data, a programming timer runs for `WR_CYCLES` core clocks. While the timer runs, the device does not answer its own address.

States of the state machine:
- `ST_IDLE`: waits for a start.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the address acknowledge.
- `ST_WORD`: shifts in the word address.
- `ST_WORD_ACK`: drives the word-address acknowledge.
- `ST_WR_DATA`: shifts in a data byte.
- `ST_WR_ACK`: drives the data acknowledge.
- `ST_RD_DATA`: shifts out a byte.
- `ST_RD_ACK`: samples the host's acknowledge.

Transitions between states:
- From any state, a start goes to `ST_ADDR` and a stop goes to `ST_IDLE`.
- In `ST_ADDR`, after eight bits a matching address goes to `ST_ADDR_ACK`. A mismatch, or any address while the device is programming, goes to `ST_IDLE`.
- `ST_ADDR_ACK` goes to `ST_RD_DATA` when the read bit is 1, and to `ST_WORD` when it is 0.
- `ST_WORD` goes to `ST_WORD_ACK`, and `ST_WORD_ACK` goes to `ST_WR_DATA`.
- `ST_WR_DATA` goes to `ST_WR_ACK`, and `ST_WR_ACK` goes back to `ST_WR_DATA`.
- `ST_RD_DATA` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RD_DATA` if the host acknowledged, and to `ST_IDLE` if it did not.

Top module: `spd_eeprom`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0) and every upper-half location (word address 128..255) reads 8'hFF.
- R2: The device acknowledges only the address byte {4'b1010, strap[2:0], rw}, with rw in bit 0 (1 = read). For any other address, the acknowledge slot is left released.
- R3: A write transfer carries the address byte, the word address, then the data byte, and all three are acknowledged. Data written to word addresses 128..255 reads back unchanged.
- R4: Writes to word addresses 0..127 are acknowledged but change nothing. These locations always read as address XOR 8'hA5.
- R5: A repeated start after the word-address byte, followed by the read address byte, returns data starting at that word address, most significant bit first.
- R6: During a sequential read the word address increments after each byte and wraps from 255 to 0.
- R7: For `WR_CYCLES` core clocks after a stop that ended a write, the device leaves its address unacknowledged and never pulls the data line low. After that time it answers again.
- R8: The pull-low enable changes only in the cycle after a detected clock fall, start or stop, never while the clock line is high. After the host's not-acknowledge and stop, the line is released.
- R9: A read transfer with no word address continues from the location after the last byte accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 3 | Low three bits of the bus address |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The hardest situation to reach is the programming window. The device must go silent only after a stop that followed a data byte, and it must come back only after the timer expires. This behaviour cannot be seen on any status port. The stimulus writes a byte and, straight after the stop, tries the address again. It expects no acknowledge. It then waits past `WR_CYCLES` and repeats the attempt, now expecting an acknowledge. The address-wrap case is reached by starting a random read at 254 and reading four bytes, then issuing a bare read to confirm where the pointer stopped.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } spd_state_e;

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic scl_p;
    logic sda_p;
    logic scl_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_q <= 1'b1;
                    sda_q <= 1'b1;
                end else begin
                    scl_q <= scl_i;
                    sda_q <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
                    sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_q[SYNC_STAGES-1];
    assign sda_s = sda_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/spd_store.sv
module spd_store #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  ROM_SEED = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int HALF = 1 << (ADDR_W - 1);

    logic [DATA_W-1:0] user_mem [HALF];
    logic [ADDR_W-2:0] low_addr;
    logic [DATA_W-1:0] rom_word;

    assign low_addr = addr[ADDR_W-2:0];
    assign rom_word = DATA_W'(addr) ^ DATA_W'(ROM_SEED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HALF; i++) begin
                user_mem[i] <= '1;
            end
        end else if (we && addr[ADDR_W-1]) begin
            user_mem[low_addr] <= wdata;
        end
    end

    assign rdata = addr[ADDR_W-1] ? user_mem[low_addr] : rom_word;
endmodule

// File: rtl/spd_wr_timer.sv
module spd_wr_timer #(
    parameter int WR_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_start,
    output logic busy
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (prog_start) begin
            remain <= CNT_W'(WR_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/spd_ctrl.sv
module spd_ctrl
    import spd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strap,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              prog_start,
    output logic              sda_oe
);
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    spd_state_e        state;
    spd_state_e        state_n;
    logic [7:0]        rx_sh;
    logic [7:0]        tx_sh;
    logic [3:0]        bit_cnt;
    logic [ADDR_W-1:0] ptr;
    logic              rw_q;
    logic              host_ack;
    logic              wr_pending;
    logic              byte_full;
    logic              addr_hit;
    logic              shifting_in;

    assign byte_full   = (bit_cnt == BITS_PER_BYTE);
    assign addr_hit    = (rx_sh[7:1] == {DEV_TYPE, strap}) && !busy;
    assign shifting_in = (state == ST_ADDR) || (state == ST_WORD) || (state == ST_WR_DATA);

    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_full) state_n = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_n = rw_q ? ST_RD_DATA : ST_WORD;
                ST_WORD:     if (scl_fall && byte_full) state_n = ST_WORD_ACK;
                ST_WORD_ACK: if (scl_fall) state_n = ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && byte_full) state_n = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_n = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && byte_full) state_n = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_n = host_ack ? ST_RD_DATA : ST_IDLE;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh      <= '0;
            tx_sh      <= '1;
            bit_cnt    <= '0;
            ptr        <= '0;
            rw_q       <= 1'b0;
            host_ack   <= 1'b0;
            wr_pending <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt    <= '0;
            wr_pending <= 1'b0;
            tx_sh      <= '1;
        end else begin
            if (scl_rise) begin
                if (shifting_in) begin
                    rx_sh   <= {rx_sh[6:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (state == ST_RD_DATA) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (state == ST_RD_ACK) begin
                    host_ack <= !sda_s;
                end
            end
            if (scl_fall) begin
                case (state)
                    ST_ADDR: begin
                        if (byte_full) begin
                            rw_q    <= rx_sh[0];
                            bit_cnt <= '0;
                        end
                    end
                    ST_ADDR_ACK: begin
                        bit_cnt <= '0;
                        tx_sh   <= rw_q ? mem_rdata : 8'hFF;
                    end
                    ST_WORD: begin
                        if (byte_full) begin
                            ptr     <= rx_sh[ADDR_W-1:0];
                            bit_cnt <= '0;
                        end
                    end
                    ST_WR_DATA: begin
                        if (byte_full) begin
                            ptr        <= ptr + 1'b1;
                            wr_pending <= 1'b1;
                            bit_cnt    <= '0;
                        end
                    end
                    ST_WORD_ACK, ST_WR_ACK: begin
                        bit_cnt <= '0;
                    end
                    ST_RD_DATA: begin
                        if (byte_full) begin
                            ptr     <= ptr + 1'b1;
                            bit_cnt <= '0;
                            tx_sh   <= 8'hFF;
                        end else begin
                            tx_sh <= {tx_sh[6:0], 1'b1};
                        end
                    end
                    ST_RD_ACK: begin
                        tx_sh <= host_ack ? mem_rdata : 8'hFF;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_WORD_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_DATA:                          sda_oe = !tx_sh[7];
            default:                             sda_oe = 1'b0;
        endcase
    end

    assign mem_addr   = ptr;
    assign mem_wdata  = rx_sh;
    assign mem_we     = (state == ST_WR_DATA) && scl_fall && byte_full && !start_det && !stop_det;
    assign prog_start = stop_det && wr_pending;
endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom #(
    parameter int         ADDR_W      = 8,
    parameter int         WR_CYCLES   = 400,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ROM_SEED    = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              busy;
    logic              prog_start;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;

    spd_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    spd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap      (strap),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .busy       (busy),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .prog_start (prog_start),
        .sda_oe     (sda_oe)
    );

    spd_store #(.ADDR_W(ADDR_W), .DATA_W(8), .ROM_SEED(ROM_SEED)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    spd_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_start (prog_start),
        .busy       (busy)
    );
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic busy,
    input logic prog_start,
    input logic mem_we,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det
);
    p_silent_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    p_prog_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);

    p_busy_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(prog_start));

    p_no_store_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !busy);

    p_drive_on_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));
endmodule

bind spd_eeprom spd_eeprom_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_oe     (sda_oe),
    .busy       (busy),
    .prog_start (prog_start),
    .mem_we     (mem_we),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det)
);

// File: tb/spd_eeprom_test.sv
module spd_eeprom_test;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 8;
    localparam int         WR_CYC     = 400;
    localparam logic [2:0] STRAP      = 3'b101;
    localparam logic [7:0] DEV_W      = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R      = {4'b1010, STRAP, 1'b1};
    localparam logic [7:0] SEED       = 8'hA5;
    localparam int         NVEC       = 5;
    // {word address, write data, expected read-back}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h80, 8'h3C, 8'h3C},
        {8'hC7, 8'h5A, 8'h5A},
        {8'hFF, 8'h81, 8'h81},
        {8'h10, 8'h77, 8'h10 ^ SEED},
        {8'h7F, 8'h00, 8'h7F ^ SEED}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_fail = 0;
    int   hi_changes = 0;
    logic prev_oe = 1'b0;

    assign sda_line = !(m_low || sda_oe);

    always #(CLK_PERIOD / 2) clk = ~clk;

    spd_eeprom #(.WR_CYCLES(WR_CYC)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .strap  (STRAP),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    // R8 monitor: pull-low enable must not move while the clock line is high
    always @(negedge clk) begin
        if (rst_n && scl && (sda_oe != prev_oe)) hi_changes++;
        prev_oe <= sda_oe;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b1; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic bus_restart();
        m_low = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        m_low = 1'b1; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        m_low = 1'b0; wait_q(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; wait_q();
            scl = 1'b1;    wait_q(2);
            scl = 1'b0;    wait_q();
        end
        m_low = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        ack = !sda_line;
        wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl = 1'b1; wait_q();
            b[i] = sda_line;
            wait_q();
            scl = 1'b0;
        end
        wait_q();
        m_low = give_ack; wait_q();
        scl = 1'b1;       wait_q(2);
        scl = 1'b0;       wait_q();
        m_low = 1'b0;
    endtask

    task automatic write_byte(input string req, input logic [7:0] wa, input logic [7:0] d);
        logic a;
        bus_start();
        send_byte(DEV_W, a); check({req, " addr ack"}, {7'd0, a}, 8'd1);
        send_byte(wa, a);    check({req, " word ack"}, {7'd0, a}, 8'd1);
        send_byte(d, a);     check({req, " data ack"}, {7'd0, a}, 8'd1);
        bus_stop();
    endtask

    task automatic random_read(input logic [7:0] wa, input int n, output logic [7:0] bytes [4]);
        logic a;
        bus_start();
        send_byte(DEV_W, a); check("R5 addr ack", {7'd0, a}, 8'd1);
        send_byte(wa, a);    check("R5 word ack", {7'd0, a}, 8'd1);
        bus_restart();
        send_byte(DEV_R, a); check("R5 read addr ack", {7'd0, a}, 8'd1);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, bytes[k]);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rb [4];
        logic a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        check("R1 sda released", {7'd0, sda_oe}, 8'd0);
        random_read(8'h80, 1, rb);
        check("R1 upper reset value", rb[0], 8'hFF);

        // R3 / R4 / R5: vector table of write then random read
        for (int v = 0; v < NVEC; v++) begin
            write_byte(VEC[v][23] ? "R3" : "R4", VEC[v][23:16], VEC[v][15:8]);
            repeat (WR_CYC + 50) @(negedge clk);
            random_read(VEC[v][23:16], 1, rb);
            check(VEC[v][23] ? "R3 readback" : "R4 locked readback", rb[0], VEC[v][7:0]);
        end

        // R7: programming window
        write_byte("R7", 8'h90, 8'h11);
        bus_start();
        send_byte(DEV_W, a);
        check("R7 nack while busy", {7'd0, a}, 8'd0);
        bus_stop();
        repeat (WR_CYC + 50) @(negedge clk);
        bus_start();
        send_byte(DEV_W, a);
        check("R7 ack after window", {7'd0, a}, 8'd1);
        bus_stop();
        repeat (20) @(negedge clk);
        random_read(8'h90, 1, rb);
        check("R7 programmed data", rb[0], 8'h11);

        // R2: foreign address
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, a);
        check("R2 foreign addr nack", {7'd0, a}, 8'd0);
        bus_stop();
        bus_start();
        send_byte({4'b0101, STRAP, 1'b1}, a);
        check("R2 wrong type nack", {7'd0, a}, 8'd0);
        bus_stop();

        // R6: sequential read across the top
        random_read(8'hFE, 4, rb);
        check("R6 byte 254", rb[0], 8'hFF);
        check("R6 byte 255", rb[1], 8'h81);
        check("R6 wrap to 0", rb[2], 8'h00 ^ SEED);
        check("R6 byte 1", rb[3], 8'h01 ^ SEED);

        // R9: current-address read
        bus_start();
        send_byte(DEV_R, a);
        check("R9 addr ack", {7'd0, a}, 8'd1);
        recv_byte(1'b0, rb[0]);
        bus_stop();
        check("R9 current address", rb[0], 8'h02 ^ SEED);

        // R8: line released, no movement while clock high
        check("R8 released after stop", {7'd0, sda_oe}, 8'd0);
        check("R8 changes while scl high", 8'(hi_changes), 8'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule